// File: doc/BRIEF.md
# Bit-serial accumulating adder

The block adds two unsigned WIDTH-bit operands one bit pair per enabled clock. It has a single full adder, one carry flip-flop and two right-shifting registers. The augend register also receives the sum bits, so after a pass it holds the sum and works as an accumulator. The addend register takes a fresh operand on its serial input while its current contents are shifted out. Several numbers can therefore be summed back to back without any parallel reload.

Software or a sequencer first preloads either register while the block is idle. It then pulses `start`, which arms a bit counter with WIDTH and clears the carry. It then supplies WIDTH cycles with `shift_en` high, which may be spread out with idle gaps between them. The block stops by itself after the last bit and raises `done_o`. The sum and the final carry stay on the outputs until the next start.

Top module: `ser_acc_adder`

## Requirements
- R1: While reset is asserted and in the cycles after its release, `sum_o`, `carry_o`, `busy_o` and `done_o` are all 0. The reset is asynchronous active-low and its release is synchronised over two clock edges.
- R2: While idle, `load_a` copies `a_val` into the augend register and `load_b` copies `b_val` into the addend register, both at the clock edge. While busy, both load inputs are ignored.
- R3: A `start` pulse while idle makes `busy_o` 1, `done_o` 0 and `carry_o` 0 after the next clock edge. The augend value is left unchanged.
- R4: On each cycle with `busy_o` and `shift_en` both 1, the sum of the two register LSBs and the carry is shifted into the augend MSB, and the carry-out is stored. After WIDTH such cycles, `sum_o` equals (A+B) mod 2^WIDTH and `carry_o` equals bit WIDTH of A+B.
- R5: A busy cycle with `shift_en` at 0 changes neither register, nor the carry, nor the remaining bit count.
- R6: `busy_o` stays 1 through the first WIDTH-1 enabled shifts. At the edge of the WIDTH-th enabled shift, `busy_o` drops and `done_o` rises together.
- R7: While idle, `shift_en` and `b_ser_in` have no effect. `sum_o`, `carry_o` and the addend register keep their values.
- R8: `carry_o` and `done_o` keep their values after a pass until the next accepted `start`.
- R9: During a pass, the bit on `b_ser_in` in the k-th enabled shift (k from 0) becomes bit k of the addend register. A following start without a load then adds that value to the accumulated `sum_o`.
- R10: A `start` pulse while busy is ignored. The pass continues with its count and carry intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_a | input | 1 | Parallel load of augend register when idle |
| a_val | input | WIDTH | Augend preload value |
| load_b | input | 1 | Parallel load of addend register when idle |
| b_val | input | WIDTH | Addend preload value |
| start | input | 1 | Begin a WIDTH-bit serial pass |
| shift_en | input | 1 | Advance one bit pair when busy |
| b_ser_in | input | 1 | Serial input to addend MSB, LSB-first operand |
| sum_o | output | WIDTH | Augend / accumulated sum register |
| carry_o | output | 1 | Carry flip-flop, final carry after a pass |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | Last pass completed, held until next start |

## Verification
The bench builds the block with WIDTH = 8. This makes the 2^8 wrap and the carry-out easy to reach with all-ones operands and random values. It also keeps each pass short enough to run chains of four accumulations with serially streamed addends. It also covers passes with stall gaps, stray loads and a second start inside a pass, all at a width where the bit counter passes through every value from 8 down to 0.

// File: rtl/ser_add_pkg.sv
package ser_add_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/ser_add_rst_sync.sv
module ser_add_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ser_add_shreg.sv
module ser_add_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             sh,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = q;
    if (ld)      q_d = ld_val;
    else if (sh) q_d = {ser_in, q[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/ser_add_carry_cell.sv
module ser_add_carry_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic a_bit,
  input  logic b_bit,
  input  logic clr,
  input  logic en,
  output logic sum_bit,
  output logic carry_q
);
  logic carry_d;
  logic half;

  assign half    = a_bit ^ b_bit;
  assign sum_bit = half ^ carry_q;

  always_comb begin
    carry_d = carry_q;
    if (clr)     carry_d = 1'b0;
    else if (en) carry_d = (a_bit & b_bit) | (carry_q & half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end
endmodule

// File: rtl/ser_add_ctrl.sv
module ser_add_ctrl
  import ser_add_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic shift_en,
  output logic start_go,
  output logic shift_go,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WIDTH + 1);

  seq_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  assign busy     = (state_q == ST_RUN);
  assign done     = done_q;
  assign start_go = start & ~busy;
  assign shift_go = shift_en & busy;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    if (start_go) begin
      state_d = ST_RUN;
      cnt_d   = CW'(WIDTH);
      done_d  = 1'b0;
    end else if (shift_go) begin
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  // R6: the pass ends only with done raised, never both flags at once
  p_end_sets_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q);
  p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done_q));
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(WIDTH));
  // R5: a stalled cycle keeps the count
  p_stall_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !shift_en) |=> $stable(cnt_q) && busy);
  // R10: start while busy keeps the count running down
  p_restart_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && shift_en && cnt_q > CW'(1)) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/ser_acc_adder.sv
module ser_acc_adder #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_a,
  input  logic [WIDTH-1:0] a_val,
  input  logic             load_b,
  input  logic [WIDTH-1:0] b_val,
  input  logic             start,
  input  logic             shift_en,
  input  logic             b_ser_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             rst_sync_n;
  logic             start_go, shift_go, busy, done;
  logic             ld_a_go, ld_b_go;
  logic             sum_bit, carry_q;
  logic [WIDTH-1:0] a_q, b_q;

  ser_add_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ser_add_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .shift_en(shift_en),
    .start_go(start_go), .shift_go(shift_go), .busy(busy), .done(done)
  );

  assign ld_a_go = load_a & ~busy;
  assign ld_b_go = load_b & ~busy;

  ser_add_shreg #(.WIDTH(WIDTH)) u_areg (
    .clk(clk), .rst_n(rst_sync_n), .ld(ld_a_go), .ld_val(a_val),
    .sh(shift_go), .ser_in(sum_bit), .q(a_q)
  );

  ser_add_shreg #(.WIDTH(WIDTH)) u_breg (
    .clk(clk), .rst_n(rst_sync_n), .ld(ld_b_go), .ld_val(b_val),
    .sh(shift_go), .ser_in(b_ser_in), .q(b_q)
  );

  ser_add_carry_cell u_fa (
    .clk(clk), .rst_n(rst_sync_n), .a_bit(a_q[0]), .b_bit(b_q[0]),
    .clr(start_go), .en(shift_go), .sum_bit(sum_bit), .carry_q(carry_q)
  );

  assign sum_o   = a_q;
  assign carry_o = carry_q;
  assign busy_o  = busy;
  assign done_o  = done;

  // R3: accepted start clears carry and done, enters busy
  p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start && !busy && !load_a) |=> busy && !carry_q && !done && $stable(a_q));
  // R5: stall keeps both registers and the carry
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && !shift_en) |=> $stable(a_q) && $stable(b_q) && $stable(carry_q));
  // R7 / R8: idle without start or load keeps everything
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && !start && !load_a && !load_b) |=>
      $stable(a_q) && $stable(b_q) && $stable(carry_q) && $stable(done));
  // R2: loads are ignored while a pass runs
  p_no_load_busy_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && !shift_en && load_a) |=> $stable(a_q));
  // R9: streamed bit lands in the addend MSB
  p_serial_in_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && shift_en) |=> b_q[WIDTH-1] == $past(b_ser_in));
endmodule

// File: tb/ser_acc_adder_bench.sv
module ser_acc_adder_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_a = 1'b0, load_b = 1'b0, start = 1'b0;
  logic         shift_en = 1'b0, b_ser_in = 1'b0;
  logic [W-1:0] a_val = '0, b_val = '0;
  logic [W-1:0] sum_o;
  logic         carry_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [W:0]   exp_q[$];
  logic [W-1:0] a_m = '0, b_m = '0;
  logic         done_d = 1'b0;

  always #10 clk = ~clk;

  ser_acc_adder #(.WIDTH(W)) u_ser_acc_adder (
    .clk(clk), .rst_n(rst_n), .load_a(load_a), .a_val(a_val),
    .load_b(load_b), .b_val(b_val), .start(start), .shift_en(shift_en),
    .b_ser_in(b_ser_in), .sum_o(sum_o), .carry_o(carry_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected {carry,sum} when done rises (R4, R9)
  always @(negedge clk) begin
    if (done_o && !done_d) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 actual=%0h expected=none", {carry_o, sum_o});
      end else begin
        logic [W:0] e;
        e = exp_q.pop_front();
        if ({carry_o, sum_o} !== e) begin
          errors++;
          $display("FAIL R4 actual=%0h expected=%0h", {carry_o, sum_o}, e);
        end
      end
    end
    done_d = done_o;
  end

  task automatic run_add(input bit la, input logic [W-1:0] av, input bit lb,
                         input logic [W-1:0] bv, input logic [W-1:0] stream,
                         input bit disturb);
    logic [W:0]   e;
    logic [W-1:0] a_start;
    if (la) a_m = av;
    if (lb) b_m = bv;
    a_start = a_m;
    e = {1'b0, a_m} + {1'b0, b_m};
    exp_q.push_back(e);
    a_m = e[W-1:0];
    b_m = stream;
    @(negedge clk);
    load_a = la; a_val = av; load_b = lb; b_val = bv; start = 1'b1;
    @(negedge clk);
    load_a = 1'b0; load_b = 1'b0; start = 1'b0;
    chk("R3 busy", busy_o, 1); chk("R3 done", done_o, 0);
    chk("R3 carry", carry_o, 0); chk("R2 load", sum_o, a_start);
    if (disturb) begin
      shift_en = 1'b0; start = 1'b1; load_a = 1'b1; a_val = ~a_start;
      load_b = 1'b1; b_val = 8'h5A;
      @(negedge clk);
      start = 1'b0; load_a = 1'b0; load_b = 1'b0;
      @(negedge clk);
      chk("R5 stall sum", sum_o, a_start); chk("R5 stall busy", busy_o, 1);
      chk("R2 R10 busy", busy_o, 1);
    end
    for (int i = 0; i < W; i++) begin
      shift_en = 1'b1; b_ser_in = stream[i];
      if (disturb && i == 3) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (disturb && i == 4) begin
        shift_en = 1'b0;
        @(negedge clk);
      end
      chk("R6 busy", busy_o, (i < W-1) ? 1 : 0);
      chk("R6 done", done_o, (i == W-1) ? 1 : 0);
    end
    shift_en = 1'b0; b_ser_in = 1'b0;
  endtask

  task automatic idle_poke();
    logic [W-1:0] s;
    logic         c;
    s = sum_o; c = carry_o;
    @(negedge clk);
    shift_en = 1'b1; b_ser_in = 1'b1;
    repeat (3) @(negedge clk);
    shift_en = 1'b0; b_ser_in = 1'b0;
    @(negedge clk);
    chk("R7 sum", sum_o, s); chk("R8 carry", carry_o, c);
    chk("R8 done", done_o, 1); chk("R7 busy", busy_o, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sum", sum_o, 0); chk("R1 busy", busy_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 carry", carry_o, 0); chk("R1 done", done_o, 0);
    chk("R1 sum after", sum_o, 0);

    run_add(1, 8'h3C, 1, 8'h51, 8'h00, 0);
    run_add(1, 8'hFF, 1, 8'h01, 8'h00, 0);
    chk("R4 wrap carry", carry_o, 1);
    idle_poke();
    run_add(1, 8'hFF, 1, 8'hFF, 8'h00, 0);
    for (int k = 0; k < 6; k++)
      run_add(1, W'($urandom), 1, W'($urandom), W'($urandom), 0);

    // R9 chained accumulation: A=0, addends streamed serially
    run_add(1, 8'h00, 1, 8'h2D, 8'h9E, 0);
    run_add(0, 8'h00, 0, 8'h00, 8'hC3, 0);
    idle_poke();
    run_add(0, 8'h00, 0, 8'h00, 8'h77, 0);
    run_add(0, 8'h00, 0, 8'h00, 8'h10, 0);

    // R5 R10 R2 disturbance during a pass
    run_add(1, 8'hA7, 1, 8'h6E, 8'h00, 1);
    run_add(0, 8'h00, 0, 8'h00, 8'h00, 1);

    repeat (3) @(negedge clk);
    chk("R4 queue empty", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule